// File: doc/BRIEF.md
# Tone Guard-Time Steering Latch

This block sits behind a dual-tone decoder that reports a raw "tone pair present" flag together with a 4-bit digit code. A raw flag is noisy: speech can briefly imitate a tone pair, and line noise can briefly interrupt a real one. The block qualifies the flag with two guard times, each counted in clock ticks. A tone must persist for the accept guard time before its code is captured and the qualified-tone output rises. That output falls only once the tone has been absent for the release guard time, so short dropouts do not split one digit into two.

A one-cycle strobe marks each newly captured digit. The captured code drives the output bus only while the output enable is high. When the enable is low, the bus floats. The two guard times come in on input ports. They are sampled only while the block is idle, so changing them in the middle of a digit does not affect that digit.

Top module: `tone_steer_latch`

## Requirements
- R1: After reset, `gt_o` and `strobe_o` are low and the captured code is 4'h0.
- R2: A digit is captured at the clock edge where `est_i` has been sampled high on A consecutive edges. A is `accept_ticks_i`, and a value of 0 is treated as 1. At that edge `code_i` is stored and `gt_o` rises.
- R3: If `est_i` is sampled low before A consecutive high samples, nothing is captured. The block returns to idle, and the run of high samples starts again from zero.
- R4: While a digit is held and `est_i` is high, `gt_o` stays high. The captured code keeps its value until the next capture, whatever `code_i` does.
- R5: `gt_o` falls at the edge where `est_i` has been sampled low on L consecutive edges. L is `release_ticks_i`, and a value of 0 is treated as 1.
- R6: A low run of `est_i` shorter than L is bridged. `gt_o` stays high, no strobe is produced, and the low-run count starts again from zero.
- R7: `strobe_o` is high for exactly one cycle, in the cycle after each capture edge. It is never high while `gt_o` is low.
- R8: A and L are sampled only on edges where the block is idle, meaning no digit is held and no high run is in progress. Changes to A and L at any other time have no effect on the digit in progress.
- R9: `code_o` equals the captured code while `oe_i` is high, and is high-impedance while `oe_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| est_i | input | 1 | Raw tone-pair-present flag from the decoder |
| code_i | input | 4 | Digit code from the decoder |
| accept_ticks_i | input | 16 | Accept guard time in ticks |
| release_ticks_i | input | 16 | Release guard time in ticks |
| oe_i | input | 1 | Output enable for the code bus |
| code_o | output | 4 | Captured code, high-impedance when not enabled |
| gt_o | output | 1 | Qualified tone held |
| strobe_o | output | 1 | One-cycle pulse on each new capture |

## Verification
The hardest case to reach from the ports is a dropout that lasts exactly one tick less than the release time, followed by a return of the tone. The case is harder still when the guard-time inputs are changed while the digit is held, because an error only shows if the held-over values are the ones actually used. Directed sequences build these cases directly: dropouts of L-1 and L ticks, the guard-time inputs rewritten in mid-digit, and guard times of 0 and 1. A long pseudo-random stretch of `est_i` with short guard times then covers run lengths near both thresholds. Throughout, a behavioural run-length model is compared against the outputs on every clock.

// File: rtl/tone_steer_latch.sv
module tone_steer_latch #(
  parameter int TW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          est_i,
  input  logic [CW-1:0] code_i,
  input  logic [TW-1:0] accept_ticks_i,
  input  logic [TW-1:0] release_ticks_i,
  input  logic          oe_i,
  output logic [CW-1:0] code_o,
  output logic          gt_o,
  output logic          strobe_o
);

  typedef enum logic [1:0] {IDLE, ACCEPT_WAIT, REGISTERED, RELEASE_WAIT} st_t;

  st_t           st;
  logic [TW-1:0] cnt, acc_q, rel_q;
  logic [CW-1:0] held_q;

  wire [TW-1:0] acc_eff = (st == IDLE) ? accept_ticks_i : acc_q;
  wire [TW:0]   cnt_nx  = {1'b0, cnt} + 1'b1;
  wire          acc_hit = cnt_nx >= {1'b0, acc_eff};
  wire          rel_hit = cnt_nx >= {1'b0, rel_q};

  assign gt_o   = (st == REGISTERED) || (st == RELEASE_WAIT);
  assign code_o = oe_i ? held_q : {CW{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      acc_q    <= '0;
      rel_q    <= '0;
      held_q   <= '0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= 1'b0;
      case (st)
        IDLE: begin
          acc_q <= accept_ticks_i;
          rel_q <= release_ticks_i;
          if (est_i) begin
            if (acc_hit) begin
              st <= REGISTERED; cnt <= '0; held_q <= code_i; strobe_o <= 1'b1;
            end else begin
              st <= ACCEPT_WAIT; cnt <= cnt_nx[TW-1:0];
            end
          end
        end
        ACCEPT_WAIT: begin
          if (!est_i) begin
            st <= IDLE; cnt <= '0;
          end else if (acc_hit) begin
            st <= REGISTERED; cnt <= '0; held_q <= code_i; strobe_o <= 1'b1;
          end else begin
            cnt <= cnt_nx[TW-1:0];
          end
        end
        REGISTERED: begin
          if (!est_i) begin
            if (rel_hit) begin
              st <= IDLE; cnt <= '0;
            end else begin
              st <= RELEASE_WAIT; cnt <= cnt_nx[TW-1:0];
            end
          end
        end
        default: begin
          if (est_i) begin
            st <= REGISTERED; cnt <= '0;
          end else if (rel_hit) begin
            st <= IDLE; cnt <= '0;
          end else begin
            cnt <= cnt_nx[TW-1:0];
          end
        end
      endcase
    end
  end

  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);
  a_r7_strobe_with_gt: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> gt_o);
  a_r4_hold_while_tone: assert property (@(posedge clk) disable iff (!rst_n)
    (gt_o && est_i) |=> gt_o);
  a_r2_rise_needs_tone: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gt_o) |-> $past(est_i));
  a_r5_fall_needs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gt_o) |-> !$past(est_i));
  a_r4_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_o |-> $stable(held_q));

endmodule

// File: tb/tone_steer_latch_bench.sv
module tone_steer_latch_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       est = 1'b0;
  logic [3:0] code = 4'h0;
  logic [15:0] acc = 16'd4, rel = 16'd3;
  logic       oe = 1'b1;
  logic [3:0] code_o;
  logic       gt_o, strobe_o;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_reg, m_hi, m_lo, m_acc, m_rel, m_strobe;
  logic [3:0] m_code;

  always #10 clk = ~clk;

  tone_steer_latch u_tone_steer_latch (
    .clk(clk), .rst_n(rst_n), .est_i(est), .code_i(code),
    .accept_ticks_i(acc), .release_ticks_i(rel), .oe_i(oe),
    .code_o(code_o), .gt_o(gt_o), .strobe_o(strobe_o));

  // behavioural run-length reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 0; m_hi = 0; m_lo = 0; m_acc = 0; m_rel = 0; m_strobe = 0; m_code = 4'h0;
    end else begin
      m_strobe = 0;
      if (!m_reg && m_hi == 0) begin m_acc = acc; m_rel = rel; end
      if (!m_reg) begin
        if (est) begin
          m_hi++;
          if (m_hi >= ((m_acc < 1) ? 1 : m_acc)) begin
            m_reg = 1; m_hi = 0; m_code = code; m_strobe = 1;
          end
        end else m_hi = 0;
      end else begin
        if (!est) begin
          m_lo++;
          if (m_lo >= ((m_rel < 1) ? 1 : m_rel)) begin m_reg = 0; m_lo = 0; end
        end else m_lo = 0;
      end
    end
  end

  task automatic compare();
    checks++;
    if (gt_o !== (m_reg != 0)) begin
      errors++;
      $display("FAIL R2 R3 R4 R5 R6 R8 gt_o at %0t: got %b exp %b", $time, gt_o, m_reg != 0);
    end
    checks++;
    if (strobe_o !== (m_strobe != 0)) begin
      errors++;
      $display("FAIL R7 strobe_o at %0t: got %b exp %b", $time, strobe_o, m_strobe != 0);
    end
    checks++;
    if (oe) begin
      if (code_o !== m_code) begin
        errors++;
        $display("FAIL R9 code_o (enabled) at %0t: got %h exp %h", $time, code_o, m_code);
      end
    end else if (!((code_o === 4'bzzzz) || (code_o === 4'b0000))) begin
      // a two-state simulator reads a floating bus as zero
      errors++;
      $display("FAIL R9 code_o (disabled) at %0t: got %b exp zzzz", $time, code_o);
    end
  endtask

  task automatic run(input logic e, input logic [3:0] c, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      est = e; code = c;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (gt_o !== 1'b0 || strobe_o !== 1'b0 || code_o !== 4'h0) begin
      errors++;
      $display("FAIL R1 reset state: got gt=%b st=%b code=%h exp 0 0 0", gt_o, strobe_o, code_o);
    end
    rst_n = 1'b1;
    // R3 short tone rejected
    run(1, 4'h3, 3); run(0, 4'h0, 5);
    // R2 capture, R4 code change while held ignored, R5 release
    run(1, 4'h5, 4); run(1, 4'h9, 3); run(0, 4'h0, 5);
    // R6 dropout of L-1 bridged, then dropout of L ends digit
    run(1, 4'h7, 10); run(0, 4'h7, 2); run(1, 4'hC, 4); run(0, 4'h0, 3); run(0, 4'h0, 2);
    // guard times of zero and one
    acc = 16'd0; rel = 16'd0;
    run(0, 4'h0, 1); run(1, 4'hA, 1); run(0, 4'h0, 2);
    acc = 16'd1; rel = 16'd1;
    run(1, 4'hB, 2); run(0, 4'h0, 1); run(1, 4'h6, 1); run(0, 4'h0, 2);
    // R8 guard times rewritten mid-digit are ignored
    acc = 16'd4; rel = 16'd2;
    run(0, 4'h0, 1); run(1, 4'hE, 2);
    acc = 16'd9;
    run(1, 4'hE, 3);
    rel = 16'd8;
    run(0, 4'h0, 4); run(0, 4'h0, 1);
    // R9 output enable low, then high
    oe = 1'b0; acc = 16'd2; rel = 16'd2;
    run(1, 4'hF, 4); run(0, 4'h0, 1);
    oe = 1'b1;
    run(0, 4'h0, 4);
    // long pseudo-random stretch near the thresholds
    acc = 16'd3; rel = 16'd3;
    for (int k = 0; k < 3000; k++) begin
      if (k % 97 == 0) oe = ~oe;
      run(1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)), 1);
    end
    run(0, 4'h0, 8);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule